// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and the next memory level. A store from the CPU is finished the moment the buffer accepts it. The buffer then writes its entries to memory in the background, oldest first. Each entry covers one aligned block. It holds the block address, one data word per word slot, a mask that marks which slots hold valid data, and a flag that marks I/O space. A store to a block that is already buffered is folded into that entry instead of taking a new one. I/O stores are never combined: each one takes its own entry and leaves in program order.

A read miss does not wait for the buffer to empty. Its block address is compared with every live entry. If nothing matches, the read takes the memory port ahead of the queued writes. If an entry matches, entries drain oldest first until no match remains, and then the read goes out. The memory port carries one request per handshake: either a read of a block, or a write of one entry with a per-word mask.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid_o` is 0, `st_ready_o` is 1 and `rd_ready_o` is 0.
- R2: A store is taken on a clock edge where `st_valid_i` and `st_ready_o` are both 1. Each buffered entry later leaves as a single memory write (`mem_we_o`=1) that carries the entry's block address. One entry is removed per accepted write handshake.
- R3: A non-I/O store merges into an existing entry when the youngest live entry with the same block address is non-I/O. The store sets that word's bit in the entry's mask (bit w for word w) and writes the word's data into data bits [w*DATA_W +: DATA_W]. No new entry is taken.
- R4: An I/O store (`st_io_i`=1) always takes a new entry and never receives a merge. I/O entries drain in store order with `mem_io_o`=1.
- R5: When a read miss matches no live entry, the memory port carries it in the same cycle, ahead of pending writes: `mem_we_o`=0, `mem_blk_o`=`rd_blk_i`, and `rd_ready_o` follows `mem_ready_i`.
- R6: When a read miss matches a live entry, `rd_ready_o` stays 0. Writes drain oldest first until no entry matches, and then the read is issued.
- R7: When all DEPTH entries are in use, `st_ready_o` is 0 for a store that cannot merge. A store that can merge is still accepted.
- R8: A store to the block of the head entry, in the same cycle that entry's write handshake completes, takes a new entry holding only its own word.
- R9: Entries drain oldest first. Each write sends only the words marked valid. Words outside the mask are driven as 0.
- R10: When a merge writes a word that is already valid, the newer data replaces the older data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_io_i | input | 1 | Store targets I/O space |
| st_blk_i | input | BLK_W | Store block address |
| st_word_i | input | WIDX_W | Word index inside the block |
| st_data_i | input | DATA_W | Store data |
| rd_valid_i | input | 1 | Read miss request |
| rd_ready_o | output | 1 | Read miss taken by memory this cycle |
| rd_blk_i | input | BLK_W | Read miss block address |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | 1 = write of head entry, 0 = read |
| mem_io_o | output | 1 | Write belongs to I/O space |
| mem_blk_o | output | BLK_W | Block address of the request |
| mem_mask_o | output | WORDS | Per-word valid mask of a write |
| mem_data_o | output | WORDS*DATA_W | Write data, word w at bits [w*DATA_W +: DATA_W] |

## Verification
The bench builds the block with DEPTH=3, WORDS=4, DATA_W=16 and BLK_W=10. A depth that is not a power of two makes the head and tail pointers wrap through a modulo path within a few stores. It also lets the full condition be reached after three entries, both with a store that merges and with one that does not. Four words per block give masks with gaps, so the bench can check that unused words are zero. Holding `mem_ready_i` low keeps entries queued, which allows read bypass, read conflict draining and the head-drain merge exclusion to be set up cycle by cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {MEM_RD = 1'b0, MEM_WR = 1'b1} mem_op_e;

  // circular index: base + off modulo depth
  function automatic int wrap_idx(input int base, input int off, input int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/wbuf_lookup.sv
module wbuf_lookup #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 26,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [BLK_W-1:0] slot_blk_i [DEPTH],
  input  logic [PTR_W-1:0] head_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [BLK_W-1:0] key_i,
  output logic [DEPTH-1:0] hit_o
);
  always_comb begin
    hit_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = wbuf_pkg::wrap_idx(int'(head_i), k, DEPTH);
      if (k < int'(count_i) && slot_blk_i[s] == key_i) hit_o[s] = 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int BLK_W  = 26,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_DW = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              io_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic              io_o,
  output logic [WORDS-1:0]  mask_o,
  output logic [BLK_DW-1:0] data_o
);
  logic [BLK_DW-1:0] nxt_data;
  logic [WORDS-1:0]  sel;

  assign sel = WORDS'(1) << widx_i;

  always_comb begin
    nxt_data = data_o;
    for (int w = 0; w < WORDS; w++) begin
      if (widx_i == WIDX_W'(w)) nxt_data[w*DATA_W +: DATA_W] = wdata_i;
      else if (alloc_i)         nxt_data[w*DATA_W +: DATA_W] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_o  <= '0;
      io_o   <= 1'b0;
      mask_o <= '0;
      data_o <= '0;
    end else if (alloc_i) begin
      blk_o  <= blk_i;
      io_o   <= io_i;
      mask_o <= sel;
      data_o <= nxt_data;
    end else if (merge_i) begin
      mask_o <= mask_o | sel;
      data_o <= nxt_data;
    end
  end

  // R3
  merge_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> (|mask_o && !io_o));
  // R4
  alloc_merge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && merge_i));
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int DEPTH  = 4,
  parameter int BLK_W  = 26,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_DW = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic              st_io_i,
  input  logic [BLK_W-1:0]  st_blk_i,
  input  logic [WIDX_W-1:0] st_word_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [BLK_W-1:0]  rd_blk_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic              mem_io_o,
  output logic [BLK_W-1:0]  mem_blk_o,
  output logic [WORDS-1:0]  mem_mask_o,
  output logic [BLK_DW-1:0] mem_data_o
);
  import wbuf_pkg::*;

  logic [PTR_W-1:0]  head_q, tail;
  logic [CNT_W-1:0]  count_q;
  logic [BLK_W-1:0]  slot_blk  [DEPTH];
  logic              slot_io   [DEPTH];
  logic [WORDS-1:0]  slot_mask [DEPTH];
  logic [BLK_DW-1:0] slot_data [DEPTH];
  logic [DEPTH-1:0]  st_hit, rd_hit;
  logic [PTR_W-1:0]  st_young;
  logic              st_any, st_young_io;
  logic              full, rd_go, wr_offer, pop, can_merge, st_fire, do_merge, do_alloc;
  mem_op_e           op;

  wbuf_lookup #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_st_lkp (
    .slot_blk_i(slot_blk), .head_i(head_q), .count_i(count_q),
    .key_i(st_blk_i), .hit_o(st_hit));

  wbuf_lookup #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_rd_lkp (
    .slot_blk_i(slot_blk), .head_i(head_q), .count_i(count_q),
    .key_i(rd_blk_i), .hit_o(rd_hit));

  // youngest live match wins so merged data never lands behind a newer copy
  always_comb begin
    st_any      = 1'b0;
    st_young    = '0;
    st_young_io = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = wrap_idx(int'(head_q), k, DEPTH);
      if (st_hit[s]) begin
        st_any      = 1'b1;
        st_young    = PTR_W'(s);
        st_young_io = slot_io[s];
      end
    end
  end

  assign tail      = PTR_W'(wrap_idx(int'(head_q), int'(count_q), DEPTH));
  assign full      = (count_q == CNT_W'(DEPTH));
  assign rd_go     = rd_valid_i && !(|rd_hit);
  assign wr_offer  = !rd_go && (count_q != '0);
  assign pop       = wr_offer && mem_ready_i;
  assign can_merge = !st_io_i && st_any && !st_young_io && !(pop && st_young == head_q);
  assign st_ready_o = can_merge || !full;
  assign st_fire   = st_valid_i && st_ready_o;
  assign do_merge  = st_fire && can_merge;
  assign do_alloc  = st_fire && !can_merge;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wbuf_entry #(.BLK_W(BLK_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_entry (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .alloc_i(do_alloc && tail == PTR_W'(i)),
      .merge_i(do_merge && st_young == PTR_W'(i)),
      .blk_i(st_blk_i), .io_i(st_io_i), .widx_i(st_word_i), .wdata_i(st_data_i),
      .blk_o(slot_blk[i]), .io_o(slot_io[i]), .mask_o(slot_mask[i]), .data_o(slot_data[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop) head_q <= PTR_W'(wrap_idx(int'(head_q), 1, DEPTH));
      count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(pop);
    end
  end

  assign op          = wr_offer ? MEM_WR : MEM_RD;
  assign mem_valid_o = rd_go || wr_offer;
  assign mem_we_o    = (op == MEM_WR);
  assign mem_io_o    = wr_offer && slot_io[head_q];
  assign mem_blk_o   = wr_offer ? slot_blk[head_q]  : rd_blk_i;
  assign mem_mask_o  = wr_offer ? slot_mask[head_q] : '0;
  assign mem_data_o  = wr_offer ? slot_data[head_q] : '0;
  assign rd_ready_o  = rd_go && mem_ready_i;

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R7
  stall_only_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_ready_o) |-> full);
  // R2
  drain_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o && mem_ready_i && !st_fire) |=> count_q == $past(count_q) - CNT_W'(1));
  // R4
  io_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_fire && st_io_i && !(mem_valid_o && mem_we_o && mem_ready_i)) |=> count_q == $past(count_q) + CNT_W'(1));
  // R5
  rd_empty_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && count_q == '0) |-> (mem_valid_o && !mem_we_o && mem_blk_o == rd_blk_i));
  // R6
  rd_held_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && mem_ready_i && !rd_ready_o) |-> (mem_valid_o && mem_we_o));
  // R9
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o) |-> (|mem_mask_o));
endmodule

// File: tb/merge_wbuf_bench.sv
`timescale 1ns/1ps
module merge_wbuf_bench;
  localparam int DEPTH = 3, BLK_W = 10, WORDS = 4, DATA_W = 16;
  localparam int BLK_DW = WORDS * DATA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, st_io = 0, rd_valid = 0, mem_ready = 0;
  logic [BLK_W-1:0] st_blk = '0, rd_blk = '0;
  logic [1:0] st_word = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic st_ready, rd_ready, mem_valid, mem_we, mem_io;
  logic [BLK_W-1:0] mem_blk;
  logic [WORDS-1:0] mem_mask;
  logic [BLK_DW-1:0] mem_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  merge_wbuf #(.DEPTH(DEPTH), .BLK_W(BLK_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_merge_wbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_io_i(st_io),
    .st_blk_i(st_blk), .st_word_i(st_word), .st_data_i(st_data),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_blk_i(rd_blk),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we), .mem_io_o(mem_io),
    .mem_blk_o(mem_blk), .mem_mask_o(mem_mask), .mem_data_o(mem_data));

  function automatic logic [BLK_DW-1:0] pk(input logic [15:0] w0, w1, w2, w3);
    return {w3, w2, w1, w0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at posedge+1; returns ready seen before the edge
  task automatic do_store(input logic [BLK_W-1:0] b, input logic [1:0] w,
                          input logic [15:0] d, input logic io, output logic rdy);
    st_valid = 1; st_blk = b; st_word = w; st_data = d; st_io = io;
    @(negedge clk); rdy = st_ready;
    @(posedge clk); #1 st_valid = 0; st_io = 0;
  endtask

  task automatic chk_wr(input string req, input logic [BLK_W-1:0] b, input logic [3:0] m,
                        input logic [BLK_DW-1:0] d, input logic io);
    @(negedge clk);
    chk(mem_valid && mem_we, req, {mem_valid, mem_we}, 2'b11);
    chk(mem_blk == b, req, mem_blk, b);
    chk(mem_mask == m, req, mem_mask, m);
    chk(mem_data == d, req, mem_data, d);
    chk(mem_io == io, req, mem_io, io);
  endtask

  task automatic pulse_mem();
    mem_ready = 1; @(posedge clk); #1 mem_ready = 0;
  endtask

  task automatic chk_empty(input string req);
    @(negedge clk);
    chk(!mem_valid && st_ready, req, {mem_valid, st_ready}, 2'b01);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!mem_valid, "R1 mem_valid", mem_valid, 0);
    chk(st_ready, "R1 st_ready", st_ready, 1);
    chk(!rd_ready, "R1 rd_ready", rd_ready, 0);
  endtask

  task automatic t_merge();
    logic r;
    do_store(10'd5, 2'd0, 16'h1111, 0, r);
    do_store(10'd5, 2'd2, 16'h2222, 0, r);
    do_store(10'd5, 2'd2, 16'h3333, 0, r); // R10 overwrite
    chk(r, "R3 merge ready", r, 1);
    chk_wr("R3 R10 merged write", 10'd5, 4'b0101, pk(16'h1111, 0, 16'h3333, 0), 0);
    pulse_mem();
    chk_empty("R2 single write drained");
  endtask

  task automatic t_io_full();
    logic r;
    do_store(10'd9, 2'd1, 16'h000A, 1, r);
    do_store(10'd9, 2'd1, 16'h000B, 1, r); // R4 no merge
    do_store(10'd9, 2'd3, 16'h000C, 0, r); // youngest match is I/O -> new entry
    do_store(10'd4, 2'd0, 16'h0044, 0, r);
    chk(!r, "R7 full stall", r, 0);
    do_store(10'd9, 2'd0, 16'h000D, 0, r);
    chk(r, "R7 merge while full", r, 1);
    chk_wr("R4 io first", 10'd9, 4'b0010, pk(0, 16'h000A, 0, 0), 1);
    pulse_mem();
    chk_wr("R4 io second", 10'd9, 4'b0010, pk(0, 16'h000B, 0, 0), 1);
    pulse_mem();
    chk_wr("R9 R3 third", 10'd9, 4'b1001, pk(16'h000D, 0, 0, 16'h000C), 0);
    pulse_mem();
    chk_empty("R9 drained");
  endtask

  task automatic t_bypass();
    logic r;
    do_store(10'd7, 2'd0, 16'h0071, 0, r);
    do_store(10'd8, 2'd1, 16'h0081, 0, r);
    rd_valid = 1; rd_blk = 10'd3;
    @(negedge clk);
    chk(mem_valid && !mem_we, "R5 read first", {mem_valid, mem_we}, 2'b10);
    chk(mem_blk == 10'd3, "R5 read blk", mem_blk, 3);
    chk(!rd_ready, "R5 no ready without mem", rd_ready, 0);
    mem_ready = 1; #0.5;
    chk(rd_ready, "R5 rd_ready", rd_ready, 1);
    @(posedge clk); #1 rd_valid = 0; mem_ready = 0;
    chk_wr("R5 writes kept", 10'd7, 4'b0001, pk(16'h0071, 0, 0, 0), 0);
    pulse_mem();
    chk_wr("R9 order", 10'd8, 4'b0010, pk(0, 16'h0081, 0, 0), 0);
    pulse_mem();
    chk_empty("R5 drained");
  endtask

  task automatic t_conflict();
    logic r;
    do_store(10'd7, 2'd0, 16'h0072, 0, r);
    do_store(10'd8, 2'd1, 16'h0082, 0, r);
    rd_valid = 1; rd_blk = 10'd8; mem_ready = 1;
    @(negedge clk);
    chk(mem_we && mem_blk == 10'd7, "R6 oldest drains", mem_blk, 7);
    chk(!rd_ready, "R6 read held", rd_ready, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(mem_we && mem_blk == 10'd8, "R6 match drains", mem_blk, 8);
    chk(!rd_ready, "R6 read held 2", rd_ready, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(mem_valid && !mem_we && mem_blk == 10'd8, "R6 read after drain", {mem_valid, mem_we}, 2'b10);
    chk(rd_ready, "R6 read taken", rd_ready, 1);
    @(posedge clk); #1 rd_valid = 0; mem_ready = 0;
    chk_empty("R6 empty");
  endtask

  task automatic t_head_drain();
    logic r;
    do_store(10'd6, 2'd0, 16'h0061, 0, r);
    mem_ready = 1;
    st_valid = 1; st_blk = 10'd6; st_word = 2'd1; st_data = 16'h0062; st_io = 0;
    @(negedge clk);
    chk(st_ready, "R8 accept during drain", st_ready, 1);
    chk(mem_we && mem_mask == 4'b0001, "R8 head unchanged", mem_mask, 4'b0001);
    chk(mem_data == pk(16'h0061, 0, 0, 0), "R8 head data", mem_data, pk(16'h0061, 0, 0, 0));
    @(posedge clk); #1 st_valid = 0; mem_ready = 0;
    chk_wr("R8 new entry", 10'd6, 4'b0010, pk(0, 16'h0062, 0, 0), 0);
    pulse_mem();
    chk_empty("R8 empty");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hang exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    @(posedge clk); #1;
    t_merge();
    @(posedge clk); #1;
    t_io_full();
    @(posedge clk); #1;
    t_bypass();
    @(posedge clk); #1;
    t_conflict();
    @(posedge clk); #1;
    t_head_drain();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule